// File: doc/BRIEF.md
# Lockable Timing-Tick Divider

This block turns a fast oscillator clock into a slow periodic enable used to time program and erase steps of non-volatile memory. Software writes one 8-bit control word after reset. That word selects an optional fixed divide-by-8 front stage and a 6-bit programmable back stage. The first write since reset fixes the setting. Any later write has no effect until the next reset.

A read port returns the whole control word. The top bit is a read-only flag that shows the word has been loaded. The output is a one-cycle `tick` pulse in the oscillator domain, together with a `valid` flag. No ticks come out before the word is loaded.

Control word layout: bit 7 is the loaded flag, bit 6 enables the divide-by-8 front stage, and bits 5:0 hold the value N. The overall ratio is (N+1) when bit 6 is 0 and 8*(N+1) when bit 6 is 1. The largest ratio is 512. Software is expected to pick a setting that brings the oscillator down to roughly 150–200 kHz.

Top module: `wo_clkdiv`

## Requirements
- R1: While reset is active and on the first cycle after it, `rd_data` reads 0x00, `valid` is 0 and `tick` is 0.
- R2: The first write after reset stores `wr_data[6:0]` into bits 6:0 and sets bit 7 to 1, whatever value `wr_data[7]` carries.
- R3: Once bit 7 is 1, every further write leaves `rd_data` and the tick period unchanged until reset.
- R4: `valid` always equals bit 7 of `rd_data`.
- R5: While bit 7 is 0, `tick` stays 0 no matter how many cycles pass.
- R6: With bit 6 = 0 and bits 5:0 = N, `tick` is high in exactly one cycle out of every N+1.
- R7: With bit 6 = 1 and bits 5:0 = N, `tick` is high in exactly one cycle out of every 8*(N+1), up to the ratio of 512 at N = 63.
- R8: When the ratio is greater than 1, `tick` is never high in two consecutive cycles.
- R9: The first tick after the loading write is high in the cycle that begins R clock edges after the write edge, where R is the ratio. That is cycle index R-1, with index 0 being the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data (bit 7 ignored) |
| rd_data | output | 8 | Current control word, including the loaded flag |
| tick | output | 1 | One-cycle timing enable at the divided rate |
| valid | output | 1 | High once the control word has been loaded |

## Verification
The hardest state to reach is a loaded word followed by a second, different write. The word can only be loaded once per reset, so each new setting needs a fresh reset before the bench can load it. The bench therefore resets, loads a setting and then issues a conflicting write. It reads back the word and re-measures the gap between ticks. The period sweeps also use one reset per setting. This lets every first tick be timed from a known counter phase, which covers the full range with the front stage off and selected values up to the ratio of 512.

// File: rtl/wo_clkdiv_pkg.sv
package wo_clkdiv_pkg;
    localparam int CTRL_W  = 8;
    localparam int DIV_W   = 6;
    localparam int PRE_W   = 3;
    localparam int PRE_MAX = (1 << PRE_W) - 1;

    typedef struct packed {
        logic             loaded;
        logic             pre_on;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic int ratio_of(input ctrl_t c);
        return (int'(c.div) + 1) * (c.pre_on ? (PRE_MAX + 1) : 1);
    endfunction
endpackage

// File: rtl/wo_cfg_reg.sv
module wo_cfg_reg
    import wo_clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);
    ctrl_t wdata_c;
    logic  unused_top_bit;

    assign wdata_c        = ctrl_t'(wr_data);
    assign unused_top_bit = wdata_c.loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && !ctrl.loaded) begin
            ctrl.loaded <= 1'b1;
            ctrl.pre_on <= wdata_c.pre_on;
            ctrl.div    <= wdata_c.div;
        end
    end
endmodule

// File: rtl/wo_prescaler.sv
module wo_prescaler #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic pre_on,
    output logic step
);
    generate
        if (W > 0) begin : g_pre
            localparam logic [W-1:0] TOP = {W{1'b1}};
            logic [W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)                  cnt <= '0;
                else if (run && pre_on)   cnt <= cnt + 1'b1;
            end
            assign step = run && (!pre_on || cnt == TOP);
        end else begin : g_bypass
            logic unused_pre;
            assign unused_pre = pre_on;
            assign step       = run;
        end
    endgenerate
endmodule

// File: rtl/wo_divider.sv
module wo_divider #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         wrap;

    assign wrap = (cnt == limit);
    assign tick = step && wrap;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/wo_clkdiv.sv
module wo_clkdiv
    import wo_clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              tick,
    output logic              valid
);
    ctrl_t ctrl;
    logic  step;

    wo_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    wo_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.loaded),
        .pre_on (ctrl.pre_on),
        .step   (step)
    );

    wo_divider #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .limit (ctrl.div),
        .tick  (tick)
    );

    assign rd_data = CTRL_W'(ctrl);
    assign valid   = ctrl.loaded;
endmodule

// File: rtl/wo_clkdiv_chk.sv
module wo_clkdiv_chk
    import wo_clkdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic              tick,
    input logic              valid
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !valid && !tick)); // R1
    AST_FIRST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !valid) |=> (valid && rd_data[CTRL_W-2:0] == $past(wr_data[CTRL_W-2:0]))); // R2
    AST_WORD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        valid |=> $stable(rd_data)); // R3
    AST_VALID_MIRRORS_FLAG: assert property (@(posedge clk) disable iff (rst)
        valid == rd_data[CTRL_W-1]); // R4
    AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !tick); // R5
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (tick && rd_data[CTRL_W-2:0] != '0) |=> !tick); // R8
endmodule

bind wo_clkdiv wo_clkdiv_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick    (tick),
    .valid   (valid)
);

// File: tb/wo_clkdiv_test.sv
module wo_clkdiv_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick, valid;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wo_clkdiv uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .valid(valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Sweeps 4 periods from cycle index 0 after the write; R9 phase, R6/R7 spacing, R8 width
    task automatic run_cfg(input bit pre, input int n, input string req);
        int r = (n + 1) * (pre ? 8 : 1);
        int bad = 0;
        int first = -1;
        int cnt = 0;
        do_reset();
        do_write({1'b0, pre, 6'(n)});
        for (int i = 0; i < 4 * r; i++) begin
            if (tick !== (((i + 1) % r) == 0)) bad++;
            if (tick) begin
                cnt++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
        check(first == r - 1, "R9", first, r - 1);
        check(bad == 0 && cnt == 4, req, cnt, 4);
    endtask

    initial begin
        @(negedge clk);
        check(rd_data == 8'h00 && !valid && !tick, "R1", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h00 && !valid, "R1", rd_data, 0);

        // R5: long idle without load
        begin
            int seen = 0;
            for (int i = 0; i < 600; i++) begin
                if (tick) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R5", seen, 0);
            check(valid == rd_data[7], "R4", valid, rd_data[7]);
        end

        // R2: bit 7 of write data ignored, flag set
        do_write(8'h85);
        check(rd_data == 8'h85, "R2", rd_data, 8'h85);
        check(valid == 1'b1, "R4", valid, 1);
        do_reset();
        do_write(8'h00);
        check(rd_data == 8'h80, "R2", rd_data, 8'h80);

        // R3: second write ignored; tick gap keeps first setting
        do_reset();
        do_write(8'h43);           // pre on, n=3 -> 32
        do_write(8'h01);
        check(rd_data == 8'hC3, "R3", rd_data, 8'hC3);
        begin
            int gap = 0;
            while (!tick) @(negedge clk);
            @(negedge clk);
            gap = 1;
            while (!tick && gap < 2000) begin gap++; @(negedge clk); end
            check(gap == 32, "R3", gap, 32);
        end

        // R6: exhaustive with prescaler off
        for (int n = 0; n < 64; n++) run_cfg(1'b0, n, "R6");
        // R7: prescaler on at several values, including 512
        run_cfg(1'b1, 0, "R7");
        run_cfg(1'b1, 1, "R7");
        run_cfg(1'b1, 7, "R7");
        run_cfg(1'b1, 20, "R7");
        run_cfg(1'b1, 63, "R7");
        check(rd_data == 8'hFF && valid, "R4", rd_data, 8'hFF);

        // R1 again after loaded state
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00 && !valid && !tick, "R1", rd_data, 0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule